// File: doc/BRIEF.md
# Width-Doubling Asynchronous FIFO

This block moves a byte stream from a fast write clock into a slower read clock domain. Every write-clock cycle may carry a new byte, and the write side has no back-pressure pin. A packer in the write domain joins each two consecutive bytes into one 16-bit entry before it enters a four-entry dual-port array. The read side sees one entry for every two bytes, so a read clock at about half the write rate can keep pace with a write stream that never pauses.

The write and read pointers are binary counters one bit wider than the array address. Each pointer crosses into the other domain as a registered Gray code through a chain of two flip-flops. Empty is derived in the read domain. Full and a sticky overflow flag are derived in the write domain. The array stays small because its only job is to cover the crossing latency. The stream holds without loss only while the read clock runs slightly faster than half the write clock. When that condition fails, the lost entry is reported on the overflow flag. Each domain has its own reset, asserted asynchronously and released in step with that domain's clock.

The write input is valid-only: a byte is taken on every cycle where `wr_valid` is high. The read side follows a plain enable protocol. The consumer raises `rd_en` while `rd_empty` is low, and the word is presented with `rd_word_valid` on the following read-clock cycle.

Top module: `byte_pack_async_fifo`

## Requirements
- R1: After reset, rd_empty is 1, rd_word_valid is 0, wr_full is 0 and wr_overflow is 0, and the next byte written is taken as the low byte of a new pair.
- R2: The first byte of a pair lands in bits [7:0] of the entry and the second in bits [15:8]. An entry is created only on the cycle the second byte is taken, so a single unpaired byte leaves rd_empty at 1.
- R3: A pair that completes while wr_full is 1 is discarded and sets wr_overflow. The flag stays set until the write-side reset, and it can only rise while wr_full is 1.
- R4: When rd_en is sampled high on a read-clock edge while rd_empty is 0, the next read-clock edge presents the oldest entry on rd_word with rd_word_valid at 1. rd_en while rd_empty is 1 produces no word and does not advance the read pointer.
- R5: The array holds four entries. wr_full is 0 with three unread entries and goes to 1 in the write cycle after the fourth entry is committed.
- R6: rd_empty falls within three read-clock cycles after an entry is committed. It can rise only as a result of a read.
- R7: wr_full can rise only as a result of a write. It clears within four write-clock cycles after a read frees an entry.
- R8: Words leave in the order their pairs were written. With bytes on every write cycle and a read clock slightly faster than half the write clock, a continuous stream passes with no overflow.
- R9: Cycles with wr_valid low leave the packer's state unchanged, so idle gaps between the two bytes of a pair do not break the pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_valid | input | 1 | A byte is presented on wr_byte this cycle |
| wr_byte | input | 8 | Input byte |
| wr_full | output | 1 | Array full as seen from the write domain |
| wr_overflow | output | 1 | Sticky: an entry was dropped because the array was full |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Request one entry; honoured only while rd_empty is 0 |
| rd_word | output | 16 | Registered output word |
| rd_word_valid | output | 1 | rd_word holds a word taken on the previous read edge |
| rd_empty | output | 1 | No entry visible to the read domain |

## Verification
Results that stay within one domain are sampled at a fixed cycle:

- The read word and its valid flag are checked at the read-clock falling edge that follows the rising edge on which rd_en was taken.
- wr_full and wr_overflow are checked at the write-clock falling edge right after the rising edge that completed the pair.

Results that cross domains have two synchronizer stages plus phase uncertainty in their delay. For these the bench polls at falling edges up to a stated bound: three read cycles for rd_empty to fall and four write cycles for wr_full to clear. The check fails if the bound runs out. During streaming, each word is compared at the read falling edge where rd_word_valid is high, against a value the bench computes from the byte index.

// File: rtl/bpf_pkg.sv
package bpf_pkg;

  // Packer phase: which half of the 16-bit entry the next byte fills.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } pack_phase_e;

endpackage

// File: rtl/bpf_rst_sync.sv
// Asynchronous assert, synchronous release reset for one clock domain.
module bpf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bpf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer bus.
module bpf_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bpf_packer.sv
// Joins two consecutive bytes into one double-width entry.
module bpf_packer
  import bpf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  pack_phase_e       phase_q;
  logic [BYTE_W-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      low_q   <= '0;
    end else if (in_valid) begin
      if (phase_q == PH_LOW) begin
        low_q   <= in_byte;
        phase_q <= PH_HIGH;
      end else begin
        phase_q <= PH_LOW;
      end
    end
  end

  assign commit = in_valid && (phase_q == PH_HIGH);
  assign word   = {in_byte, low_q};
endmodule

// File: rtl/bpf_ram.sv
// Dual-clock storage: write port on one clock, registered read port on the other.
module bpf_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bpf_wr_ctrl.sv
// Write-domain pointer, full detection and sticky overflow.
module bpf_wr_ctrl #(
  parameter int ADDR_W = 2,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PTR_W-1:0]  rd_gray_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PTR_W-1:0]  wr_gray,
  output logic              full,
  output logic              overflow
);
  logic [PTR_W-1:0] bin_q, gray_q, bin_nxt, far_gray;
  logic             accept;

  // Full: the read pointer is exactly one lap behind.
  // In Gray code that means the top two bits differ and the rest match.
  assign far_gray = {~rd_gray_sync[PTR_W-1:PTR_W-2], rd_gray_sync[PTR_W-3:0]};
  assign full     = (gray_q == far_gray);
  assign accept   = commit && !full;
  assign bin_nxt  = bin_q + PTR_W'(accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q    <= '0;
      gray_q   <= '0;
      overflow <= 1'b0;
    end else begin
      bin_q    <= bin_nxt;
      gray_q   <= bin_nxt ^ (bin_nxt >> 1);
      overflow <= overflow | (commit && full);
    end
  end

  assign mem_we    = accept;
  assign mem_waddr = bin_q[ADDR_W-1:0];
  assign wr_gray   = gray_q;
endmodule

// File: rtl/bpf_rd_ctrl.sv
// Read-domain pointer, empty detection and output valid.
module bpf_rd_ctrl #(
  parameter int ADDR_W = 2,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  wr_gray_sync,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [PTR_W-1:0]  rd_gray,
  output logic              empty,
  output logic              word_valid
);
  logic [PTR_W-1:0] bin_q, gray_q, bin_nxt;
  logic             take;

  assign empty   = (gray_q == wr_gray_sync);
  assign take    = rd_en && !empty;
  assign bin_nxt = bin_q + PTR_W'(take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q      <= '0;
      gray_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      bin_q      <= bin_nxt;
      gray_q     <= bin_nxt ^ (bin_nxt >> 1);
      word_valid <= take;
    end
  end

  assign mem_re    = take;
  assign mem_raddr = bin_q[ADDR_W-1:0];
  assign rd_gray   = gray_q;
endmodule

// File: rtl/byte_pack_async_fifo.sv
module byte_pack_async_fifo #(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 2,   // must be at least 2
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              wr_full,
  output logic              wr_overflow,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_word_valid,
  output logic              rd_empty
);
  logic              wr_srst_n, rd_srst_n;
  logic              pk_commit;
  logic [WORD_W-1:0] pk_word;
  logic              mem_we, mem_re;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_at_rd, rd_gray_at_wr;

  bpf_rst_sync #(.STAGES(2)) u_wr_rst (
    .clk(wr_clk), .arst_n(wr_rst_n), .srst_n(wr_srst_n));
  bpf_rst_sync #(.STAGES(2)) u_rd_rst (
    .clk(rd_clk), .arst_n(rd_rst_n), .srst_n(rd_srst_n));

  bpf_packer #(.BYTE_W(BYTE_W)) u_pack (
    .clk(wr_clk), .rst_n(wr_srst_n), .in_valid(wr_valid), .in_byte(wr_byte),
    .commit(pk_commit), .word(pk_word));

  bpf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wctl (
    .clk(wr_clk), .rst_n(wr_srst_n), .commit(pk_commit),
    .rd_gray_sync(rd_gray_at_wr), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wr_gray(wr_gray), .full(wr_full), .overflow(wr_overflow));

  bpf_ram #(.DATA_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(pk_word),
    .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr), .rdata(rd_word));

  bpf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(wr_gray), .q(wr_gray_at_rd));
  bpf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_srst_n), .d(rd_gray), .q(rd_gray_at_wr));

  bpf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rctl (
    .clk(rd_clk), .rst_n(rd_srst_n), .rd_en(rd_en),
    .wr_gray_sync(wr_gray_at_rd), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .rd_gray(rd_gray), .empty(rd_empty), .word_valid(rd_word_valid));
endmodule

// File: rtl/bpf_checks.sv
module bpf_checks (
  input logic wr_clk,
  input logic wr_rst_n,
  input logic wr_valid,
  input logic wr_full,
  input logic wr_overflow,
  input logic rd_clk,
  input logic rd_rst_n,
  input logic rd_en,
  input logic rd_word_valid,
  input logic rd_empty
);
  // R4: a word is only presented after an honoured read request
  assert_word_after_read_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_word_valid |-> $past(rd_en && !rd_empty));

  // R3: overflow is sticky
  assert_overflow_sticky_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_overflow |=> wr_overflow);

  // R3: overflow only rises while full
  assert_overflow_needs_full_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(wr_overflow) |-> $past(wr_full));

  // R7: full cannot rise without a write
  assert_full_needs_write_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!wr_valid && !wr_full) |=> !wr_full);

  // R6: empty cannot rise without a read
  assert_empty_needs_read_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_en && !rd_empty) |=> !rd_empty);
endmodule

bind byte_pack_async_fifo bpf_checks u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid),
  .wr_full(wr_full), .wr_overflow(wr_overflow),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
  .rd_word_valid(rd_word_valid), .rd_empty(rd_empty));

// File: tb/byte_pack_async_fifo_bench.sv
module byte_pack_async_fifo_bench;
  localparam int WR_PERIOD = 20;
  localparam int RD_PERIOD = 38;  // slightly faster than half the write rate
  localparam int STREAM_WORDS = 40;

  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_rst_n = 0, rd_rst_n = 0;
  logic        wr_valid = 0, rd_en = 0;
  logic [7:0]  wr_byte = 0;
  logic        wr_full, wr_overflow, rd_word_valid, rd_empty;
  logic [15:0] rd_word;

  int checks = 0;
  int failures = 0;

  always #(WR_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  byte_pack_async_fifo u_byte_pack_async_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .wr_full(wr_full), .wr_overflow(wr_overflow),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_word(rd_word), .rd_word_valid(rd_word_valid), .rd_empty(rd_empty));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic do_reset();
    @(negedge wr_clk);
    wr_valid = 0; rd_en = 0;
    wr_rst_n = 0; rd_rst_n = 0;
    repeat (3) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (5) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge wr_clk);
    wr_valid = 1; wr_byte = b;
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic read_one(input logic [15:0] exp, input string tag);
    int waited = 0;
    @(negedge rd_clk);
    while (rd_empty && waited < 8) begin
      @(negedge rd_clk);
      waited++;
    end
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    check(rd_word_valid === 1'b1 && rd_word === exp, tag, {15'd0, rd_word_valid, rd_word},
          {16'd1, exp});
  endtask

  task automatic t_reset();
    do_reset();
    check(rd_empty === 1'b1, "R1 rd_empty", 32'(rd_empty), 1);
    check(rd_word_valid === 1'b0, "R1 rd_word_valid", 32'(rd_word_valid), 0);
    check(wr_full === 1'b0, "R1 wr_full", 32'(wr_full), 0);
    check(wr_overflow === 1'b0, "R1 wr_overflow", 32'(wr_overflow), 0);
  endtask

  task automatic t_pair_order();
    int n = 0;
    do_reset();
    put_byte(8'h11);
    repeat (6) @(negedge rd_clk);
    check(rd_empty === 1'b1, "R2 lone byte stays unstored", 32'(rd_empty), 1);
    repeat (3) @(negedge wr_clk);  // idle gap inside the pair (R9)
    put_byte(8'h22);
    @(negedge rd_clk);
    while (rd_empty && n < 5) begin
      @(negedge rd_clk);
      n++;
    end
    check(n <= 3, "R6 empty falls in time", 32'(n), 3);
    read_one(16'h2211, "R2 R9 byte order and gap");
  endtask

  task automatic t_empty_read();
    do_reset();
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    check(rd_word_valid === 1'b0, "R4 read while empty", 32'(rd_word_valid), 0);
    put_byte(8'hA5);
    put_byte(8'h5A);
    read_one(16'h5AA5, "R4 pointer unmoved by empty read");
    @(negedge rd_clk);
    check(rd_empty === 1'b1, "R6 empty after last read", 32'(rd_empty), 1);
  endtask

  task automatic t_fill_overflow();
    int n = 0;
    do_reset();
    for (int p = 0; p < 3; p++) begin
      put_byte(8'(2*p + 1));
      put_byte(8'(2*p + 2));
    end
    check(wr_full === 1'b0, "R5 not full at three", 32'(wr_full), 0);
    put_byte(8'h07);
    put_byte(8'h08);
    check(wr_full === 1'b1, "R5 full at four", 32'(wr_full), 1);
    check(wr_overflow === 1'b0, "R3 no overflow yet", 32'(wr_overflow), 0);
    put_byte(8'hEE);
    put_byte(8'hFF);
    check(wr_overflow === 1'b1, "R3 overflow on full", 32'(wr_overflow), 1);
    read_one(16'h0201, "R3 R8 entry 0");
    @(negedge wr_clk);
    while (wr_full && n < 6) begin
      @(negedge wr_clk);
      n++;
    end
    check(n <= 4, "R7 full clears after read", 32'(n), 4);
    read_one(16'h0403, "R8 entry 1");
    read_one(16'h0605, "R8 entry 2");
    read_one(16'h0807, "R3 entry 3, dropped pair absent");
    check(rd_empty === 1'b1, "R3 dropped pair not stored", 32'(rd_empty), 1);
    check(wr_overflow === 1'b1, "R3 overflow sticky", 32'(wr_overflow), 1);
    do_reset();
    check(wr_overflow === 1'b0, "R1 R3 overflow cleared by reset", 32'(wr_overflow), 0);
  endtask

  task automatic t_stream();
    int got = 0;
    int bad = 0;
    do_reset();
    fork
      begin
        for (int i = 0; i < 2*STREAM_WORDS; i++) begin
          @(negedge wr_clk);
          wr_valid = 1; wr_byte = sb(i);
        end
        @(negedge wr_clk);
        wr_valid = 0;
      end
      begin
        for (int c = 0; c < 4*STREAM_WORDS && got < STREAM_WORDS; c++) begin
          @(negedge rd_clk);
          if (rd_word_valid) begin
            if (rd_word !== {sb(2*got + 1), sb(2*got)}) begin
              bad++;
              $display("FAIL R8 stream word %0d: actual=%0h expected=%0h", got, rd_word,
                       {sb(2*got + 1), sb(2*got)});
            end
            got++;
          end
          rd_en = !rd_empty;
        end
        rd_en = 0;
      end
    join
    checks++;
    if (bad != 0) failures++;
    check(got == STREAM_WORDS, "R8 stream word count", 32'(got), STREAM_WORDS);
    check(wr_overflow === 1'b0, "R8 no overflow in stream", 32'(wr_overflow), 0);
  endtask

  initial begin
    #(WR_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_pair_order();
    t_empty_read();
    t_fill_overflow();
    t_stream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule